// File: doc/BRIEF.md
# CAN Error Status and Interrupt Unit

This block sits beside a CAN protocol engine and turns what the engine reports into a status word and three interrupt lines for software. The engine sends single-cycle event pulses for each kind of bus error, for a wake-up and for each mailbox whose transfer finished. It also drives two level signals, bus idle and node transmitting/receiving, and its two error counters. The unit records the most recent error kind and works out the warning and fault-confinement state from the counters. It latches interrupt causes in write-one-to-clear bits.

Software reaches the unit through a small register port with four word addresses: status at 0, mailbox mask at 1, mailbox flags at 2 and control at 3. The mailbox interrupt is the OR over all flags that are unmasked. The bus-off and error interrupts have their own enable bits in the control word and do not depend on the mailbox mask. The transmit error count port is one bit wider than the receive count, so it can show a count past 255. That extra range is how the engine reports bus-off.

Top module: `can_err_irq_unit`

## Requirements
- R1: Any error pulse replaces status bits 15:10 with the set of errors pulsed in that cycle. The fields are: 15:14 bit error (01 = sent dominant, saw recessive; 10 = sent recessive, saw dominant), 13 ack, 12 CRC, 11 form, 10 stuff. The value is visible after the next clock edge.
- R2: A read strobe at the status address clears bits 15:10 at the next edge. If an error pulse arrives in the same cycle as the read, the new error value is kept.
- R3: Status bit 9 is 1 when the transmit count is 96 or more. Bit 8 is 1 when the receive count is 96 or more. Bit 7 follows the bus idle input and bit 6 follows the transmitting/receiving input. All four are live, with no register.
- R4: Status bits 5:4 give the fault state: 00 error active; 01 error passive when either count is 128 or more; 10 bus-off when the transmit count is 256 or more. Bus-off takes precedence over passive. Bit 3 reads 0.
- R5: Status bit 2 is set when the unit enters bus-off, bit 1 on any error pulse, and bit 0 on a wake pulse. Writing 1 to one of these bits at the status address clears it; writing 0 leaves it alone. A set in the same cycle as a clear wins.
- R6: A done pulse on mailbox i sets flag bit i, read at address 2. Writing 1 to a bit at address 2 clears that bit and leaves every other bit unchanged. A set in the same cycle as a clear wins.
- R7: `irq_mbox` is 1 exactly when some flag bit and its mask bit (address 1, read/write) are both 1.
- R8: `irq_busoff` equals status bit 2 AND control bit 7. `irq_err` equals status bit 1 AND control bit 6. The mailbox mask affects neither.
- R9: After reset, every latched bit is 0, and so are the mask, the flags, the control word and all three interrupts.
- R10: Reads at address 3 return only bits 7:6 as written; all other bits read 0. The read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_bit_dom | input | 1 | Pulse: sent dominant, saw recessive |
| ev_bit_rec | input | 1 | Pulse: sent recessive, saw dominant |
| ev_ack | input | 1 | Pulse: acknowledge error |
| ev_crc | input | 1 | Pulse: CRC error |
| ev_form | input | 1 | Pulse: form error |
| ev_stuff | input | 1 | Pulse: stuffing error |
| ev_wake | input | 1 | Pulse: wake-up seen |
| bus_idle | input | 1 | Level: bus idle |
| node_tx_rx | input | 1 | Level: node transmitting or receiving |
| rx_err_cnt | input | CNT_W | Receive error count |
| tx_err_cnt | input | CNT_W+1 | Transmit error count, extra bit for bus-off range |
| mb_done | input | NUM_MB | Per-mailbox transfer-done pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears error kind at status) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| irq_busoff | output | 1 | Bus-off interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_mbox | output | 1 | Mailbox interrupt |

## Verification
The cases that matter most are a hardware set and a software clear of the same bit landing in the same cycle. This can happen to a mailbox flag, a status interrupt bit, or the error-kind field being cleared by a read. The bench provokes each one by driving the event pulse and the write or read strobe in the same cycle. It then expects the new event to survive: the flag or interrupt bit still 1, or the error field holding the new error instead of zero. Bus-off entry is also checked while its interrupt bit is being cleared and the count stays high. The bit must stay clear, because entry fires only once per crossing.

// File: rtl/can_eirq_pkg.sv
// Package: shared types and field positions for the CAN error status unit.
// Assumes a 16-bit register word and four word addresses.
package can_eirq_pkg;
    localparam int DATA_W = 16;

    // register word addresses
    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_MASK   = 2'd1,
        A_FLAGS  = 2'd2,
        A_CTRL   = 2'd3
    } reg_addr_e;

    // fault-confinement state as reported in status bits 5:4
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fault_e;

    // error kinds; the packed order matches status bits 15:10
    typedef struct packed {
        logic bit_rec;
        logic bit_dom;
        logic ack;
        logic crc;
        logic form;
        logic stuff;
    } err_kind_t;

    localparam int ST_KIND_LSB = 10;
    localparam int ST_TXWARN   = 9;
    localparam int ST_RXWARN   = 8;
    localparam int ST_IDLE     = 7;
    localparam int ST_TXRX     = 6;
    localparam int ST_FC_LSB   = 4;
    localparam int IRQ_BITS    = 3;   // status bits 2:0
    localparam int CTRL_BOFF   = 7;
    localparam int CTRL_ERR    = 6;
endpackage

// File: rtl/can_w1c_bits.sv
// Module: a row of write-one-to-clear flag bits.
// Each bit is set by a hardware pulse and cleared by a software write of 1.
// A set and a clear in the same cycle leave the bit set.
// Assumes set and clr are synchronous to clk.
module can_w1c_bits #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // one flag: a set wins over a clear
            always_ff @(posedge clk) begin
                if (!rst_n)      q[i] <= 1'b0;
                else if (set[i]) q[i] <= 1'b1;
                else if (clr[i]) q[i] <= 1'b0;
            end

            // R5 R6
            w1c_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> q[i]);
            // R5 R6
            w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !set[i]) |=> !q[i]);
            // R6
            w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr[i] && !set[i]) |=> (q[i] == $past(q[i])));
        end
    endgenerate
endmodule

// File: rtl/can_fault_conf.sv
// Module: works out the warning and fault-confinement state from the error counts.
// It also gives a one-cycle pulse when the node first enters bus-off.
// The transmit count is one bit wider, so its top bit set means 256 or more.
module can_fault_conf
    import can_eirq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W:0]   tx_cnt,
    output logic           tx_warn,
    output logic           rx_warn,
    output fault_e         state,
    output logic           busoff_entry
);
    localparam logic [CNT_W:0]   TX_WARN_V = (CNT_W+1)'(WARN_LVL);
    localparam logic [CNT_W-1:0] RX_WARN_V = CNT_W'(WARN_LVL);
    localparam logic [CNT_W:0]   TX_PASS_V = (CNT_W+1)'(PASSIVE_LVL);
    localparam logic [CNT_W-1:0] RX_PASS_V = CNT_W'(PASSIVE_LVL);

    logic in_busoff;
    logic busoff_q;

    // warning levels, compared live
    always_comb begin
        tx_warn = (tx_cnt >= TX_WARN_V);
        rx_warn = (rx_cnt >= RX_WARN_V);
    end

    // state decode; bus-off takes precedence over passive
    always_comb begin
        in_busoff = tx_cnt[CNT_W];
        if (in_busoff)
            state = FC_BUSOFF;
        else if ((tx_cnt >= TX_PASS_V) || (rx_cnt >= RX_PASS_V))
            state = FC_PASSIVE;
        else
            state = FC_ACTIVE;
    end

    // remember bus-off from the last cycle to find the entry edge
    always_ff @(posedge clk) begin
        if (!rst_n) busoff_q <= 1'b0;
        else        busoff_q <= in_busoff;
    end

    assign busoff_entry = in_busoff & ~busoff_q;

    // R4
    busoff_implies_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FC_BUSOFF) |-> tx_warn);
    // R5
    entry_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_entry |=> !busoff_entry);
endmodule

// File: rtl/can_err_capture.sv
// Module: holds the error kind that arrived most recently.
// Any pulse replaces the whole field. A status read clears the field,
// but an error pulse in the same cycle as the read is kept.
module can_err_capture
    import can_eirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  err_kind_t ev,
    input  logic      rd_clr,
    output err_kind_t kind_q
);
    logic any_ev;
    assign any_ev = |ev;

    // replace on any event, otherwise clear when read
    always_ff @(posedge clk) begin
        if (!rst_n)      kind_q <= '0;
        else if (any_ev) kind_q <= ev;
        else if (rd_clr) kind_q <= '0;
    end

    // R1
    ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.ack |=> kind_q.ack);
    // R1
    recent_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.crc && !ev.ack) |=> !kind_q.ack);
    // R2
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !any_ev) |=> (kind_q == '0));
endmodule

// File: rtl/can_err_irq_unit.sv
// Module: top of the CAN error status and interrupt unit.
// Builds the status word, holds the mailbox mask, flags and interrupt enables,
// and drives the bus-off, error and mailbox interrupts.
// Assumes the event pulses last one cycle, the counts come from the
// protocol engine, and the register read data is taken combinationally.
module can_err_irq_unit
    import can_eirq_pkg::*;
#(
    parameter int NUM_MB      = 16,
    parameter int CNT_W       = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_bit_dom,
    input  logic              ev_bit_rec,
    input  logic              ev_ack,
    input  logic              ev_crc,
    input  logic              ev_form,
    input  logic              ev_stuff,
    input  logic              ev_wake,
    input  logic              bus_idle,
    input  logic              node_tx_rx,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    input  logic [CNT_W:0]    tx_err_cnt,
    input  logic [NUM_MB-1:0] mb_done,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq_busoff,
    output logic              irq_err,
    output logic              irq_mbox
);
    localparam int KIND_W = $bits(err_kind_t);

    err_kind_t             ev_now;
    err_kind_t             kind_q;
    logic                  tx_warn, rx_warn, busoff_entry;
    fault_e                fstate;
    logic [IRQ_BITS-1:0]   st_irq_set, st_irq_clr, st_irq_q;
    logic [NUM_MB-1:0]     flag_clr, flag_q, mask_q;
    logic                  boff_en_q, err_en_q;
    logic                  wr_status, wr_mask, wr_flags, wr_ctrl, rd_status;
    logic [DATA_W-1:0]     status_w, flags_w, mask_w, ctrl_w;

    // pack the event pulses in status-field order
    always_comb begin
        ev_now.bit_rec = ev_bit_rec;
        ev_now.bit_dom = ev_bit_dom;
        ev_now.ack     = ev_ack;
        ev_now.crc     = ev_crc;
        ev_now.form    = ev_form;
        ev_now.stuff   = ev_stuff;
    end

    // decode register strobes
    always_comb begin
        wr_status = reg_wr && (reg_addr == A_STATUS);
        wr_mask   = reg_wr && (reg_addr == A_MASK);
        wr_flags  = reg_wr && (reg_addr == A_FLAGS);
        wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
        rd_status = reg_rd && (reg_addr == A_STATUS);
    end

    can_fault_conf #(
        .CNT_W       (CNT_W),
        .WARN_LVL    (WARN_LVL),
        .PASSIVE_LVL (PASSIVE_LVL)
    ) u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_cnt       (rx_err_cnt),
        .tx_cnt       (tx_err_cnt),
        .tx_warn      (tx_warn),
        .rx_warn      (rx_warn),
        .state        (fstate),
        .busoff_entry (busoff_entry)
    );

    can_err_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_now),
        .rd_clr (rd_status),
        .kind_q (kind_q)
    );

    // status interrupt bits: 2 bus-off entry, 1 any error, 0 wake
    always_comb begin
        st_irq_set = {busoff_entry, |ev_now, ev_wake};
        st_irq_clr = wr_status ? reg_wdata[IRQ_BITS-1:0] : '0;
    end

    can_w1c_bits #(.W(IRQ_BITS)) u_st_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (st_irq_set),
        .clr   (st_irq_clr),
        .q     (st_irq_q)
    );

    // mailbox flag clears come from writes at the flag address
    assign flag_clr = wr_flags ? reg_wdata[NUM_MB-1:0] : '0;

    can_w1c_bits #(.W(NUM_MB)) u_mb_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (mb_done),
        .clr   (flag_clr),
        .q     (flag_q)
    );

    // mailbox mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata[NUM_MB-1:0];
    end

    // control register: bus-off and error interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boff_en_q <= 1'b0;
            err_en_q  <= 1'b0;
        end else if (wr_ctrl) begin
            boff_en_q <= reg_wdata[CTRL_BOFF];
            err_en_q  <= reg_wdata[CTRL_ERR];
        end
    end

    // assemble the readable words
    always_comb begin
        status_w = '0;
        status_w[ST_KIND_LSB +: KIND_W] = kind_q;
        status_w[ST_TXWARN]             = tx_warn;
        status_w[ST_RXWARN]             = rx_warn;
        status_w[ST_IDLE]               = bus_idle;
        status_w[ST_TXRX]               = node_tx_rx;
        status_w[ST_FC_LSB +: 2]        = fstate;
        status_w[IRQ_BITS-1:0]          = st_irq_q;
        flags_w = '0;
        flags_w[NUM_MB-1:0] = flag_q;
        mask_w = '0;
        mask_w[NUM_MB-1:0] = mask_q;
        ctrl_w = '0;
        ctrl_w[CTRL_BOFF] = boff_en_q;
        ctrl_w[CTRL_ERR]  = err_en_q;
    end

    // read mux
    always_comb begin
        unique case (reg_addr)
            A_STATUS: reg_rdata = status_w;
            A_MASK:   reg_rdata = mask_w;
            A_FLAGS:  reg_rdata = flags_w;
            default:  reg_rdata = ctrl_w;
        endcase
    end

    // interrupt outputs
    always_comb begin
        irq_busoff = st_irq_q[2] & boff_en_q;
        irq_err    = st_irq_q[1] & err_en_q;
        irq_mbox   = |(flag_q & mask_q);
    end

    // R7
    mbox_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(mb_done & mask_q)) && !wr_mask) |=> irq_mbox);
    // R5
    busoff_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_entry |=> st_irq_q[2]);
    // R8
    busoff_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boff_en_q && !wr_ctrl) |=> !irq_busoff);
    // R8
    err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_en_q && !wr_ctrl) |=> !irq_err);
    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_busoff && !irq_err && !irq_mbox));
endmodule

// File: tb/can_err_irq_unit_bench.sv
module can_err_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_bit_dom = 0, ev_bit_rec = 0, ev_ack = 0, ev_crc = 0;
    logic        ev_form = 0, ev_stuff = 0, ev_wake = 0;
    logic        bus_idle = 0, node_tx_rx = 0;
    logic [7:0]  rx_err_cnt = '0;
    logic [8:0]  tx_err_cnt = '0;
    logic [15:0] mb_done = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_busoff, irq_err, irq_mbox;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    can_err_irq_unit u_can_err_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .ev_bit_dom(ev_bit_dom), .ev_bit_rec(ev_bit_rec), .ev_ack(ev_ack),
        .ev_crc(ev_crc), .ev_form(ev_form), .ev_stuff(ev_stuff),
        .ev_wake(ev_wake), .bus_idle(bus_idle), .node_tx_rx(node_tx_rx),
        .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .mb_done(mb_done),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_busoff(irq_busoff), .irq_err(irq_err), .irq_mbox(irq_mbox)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    // look at a register without a read strobe
    task automatic peek(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic clear_pulses();
        ev_bit_dom = 0; ev_bit_rec = 0; ev_ack = 0; ev_crc = 0;
        ev_form = 0; ev_stuff = 0; ev_wake = 0; mb_done = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        peek(2'd0, d); check("R9 status", d, 16'h0000);
        peek(2'd1, d); check("R9 mask", d, 16'h0000);
        peek(2'd2, d); check("R9 flags", d, 16'h0000);
        peek(2'd3, d); check("R9 ctrl", d, 16'h0000);
        check("R9 irqs", {13'd0, irq_busoff, irq_err, irq_mbox}, 16'h0000);
    endtask

    task automatic t_regmap();
        logic [15:0] d;
        wr(2'd3, 16'hFFFF);
        peek(2'd3, d); check("R10 ctrl readback", d, 16'h00C0);
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'hA5F0);
        peek(2'd1, d); check("R10 mask readback", d, 16'hA5F0);
    endtask

    task automatic t_mbox();
        logic [15:0] d;
        wr(2'd1, 16'h0005);
        @(negedge clk); mb_done = 16'h0002;
        @(negedge clk); mb_done = '0;
        peek(2'd2, d); check("R6 flag set", d, 16'h0002);
        check("R7 masked no irq", {15'd0, irq_mbox}, 16'h0000);
        @(negedge clk); mb_done = 16'h0004;
        @(negedge clk); mb_done = '0;
        check("R7 unmasked irq", {15'd0, irq_mbox}, 16'h0001);
        wr(2'd2, 16'h0002);
        peek(2'd2, d); check("R6 selective clear", d, 16'h0004);
        wr(2'd2, 16'h0000);
        peek(2'd2, d); check("R6 zero write keeps", d, 16'h0004);
        // set and clear of bit 2 in one cycle
        @(negedge clk);
        reg_wr = 1; reg_addr = 2'd2; reg_wdata = 16'h0004; mb_done = 16'h0004;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; mb_done = '0;
        peek(2'd2, d); check("R6 set wins over clear", d, 16'h0004);
        wr(2'd2, 16'hFFFF);
        peek(2'd2, d); check("R6 clear all", d, 16'h0000);
        check("R7 irq drops", {15'd0, irq_mbox}, 16'h0000);
    endtask

    task automatic t_capture();
        logic [15:0] d;
        @(negedge clk); ev_ack = 1;
        @(negedge clk); clear_pulses();
        peek(2'd0, d); check("R1 ack kind", d & 16'hFC00, 16'h2000);
        check("R5 error bit set", d & 16'h0002, 16'h0002);
        @(negedge clk); ev_crc = 1;
        @(negedge clk); clear_pulses();
        peek(2'd0, d); check("R1 most recent crc", d & 16'hFC00, 16'h1000);
        @(negedge clk); ev_bit_dom = 1;
        @(negedge clk); clear_pulses();
        peek(2'd0, d); check("R1 bit err code 01", d & 16'hFC00, 16'h4000);
        @(negedge clk); ev_bit_rec = 1; ev_stuff = 1;
        @(negedge clk); clear_pulses();
        peek(2'd0, d); check("R1 bit err code 10 plus stuff", d & 16'hFC00, 16'h8400);
        @(negedge clk); reg_rd = 1; reg_addr = 2'd0;
        @(negedge clk); reg_rd = 0;
        peek(2'd0, d); check("R2 read clears kind", d & 16'hFC00, 16'h0000);
        check("R2 read keeps irq bit", d & 16'h0002, 16'h0002);
        @(negedge clk); reg_rd = 1; reg_addr = 2'd0; ev_form = 1;
        @(negedge clk); reg_rd = 0; clear_pulses();
        peek(2'd0, d); check("R2 new error beats read", d & 16'hFC00, 16'h0800);
        wr(2'd0, 16'h0002);
        peek(2'd0, d); check("R5 error bit cleared", d & 16'h0007, 16'h0000);
    endtask

    task automatic t_levels();
        logic [15:0] d;
        @(negedge clk); rx_err_cnt = 8'd95; tx_err_cnt = 9'd95;
        peek(2'd0, d); check("R3 below warn", d & 16'h0330, 16'h0000);
        rx_err_cnt = 8'd96;
        peek(2'd0, d); check("R3 rx warn at 96", d & 16'h0330, 16'h0100);
        tx_err_cnt = 9'd96; rx_err_cnt = 8'd0;
        peek(2'd0, d); check("R3 tx warn at 96", d & 16'h0330, 16'h0200);
        tx_err_cnt = 9'd127; rx_err_cnt = 8'd127;
        peek(2'd0, d); check("R4 active at 127", d & 16'h0030, 16'h0000);
        rx_err_cnt = 8'd128;
        peek(2'd0, d); check("R4 passive rx 128", d & 16'h0030, 16'h0010);
        rx_err_cnt = 8'd0; tx_err_cnt = 9'd128;
        peek(2'd0, d); check("R4 passive tx 128", d & 16'h0030, 16'h0010);
        bus_idle = 1; node_tx_rx = 1;
        peek(2'd0, d); check("R3 idle and txrx", d & 16'h00C8, 16'h00C0);
        bus_idle = 0; node_tx_rx = 0; tx_err_cnt = 9'd0;
    endtask

    task automatic t_busoff();
        logic [15:0] d;
        wr(2'd3, 16'h0080);
        @(negedge clk); tx_err_cnt = 9'd255;
        @(negedge clk);
        peek(2'd0, d); check("R4 passive at 255", d & 16'h0034, 16'h0010);
        tx_err_cnt = 9'd256;
        @(negedge clk);
        peek(2'd0, d); check("R4 busoff at 256", d & 16'h0034, 16'h0024);
        check("R8 busoff irq", {15'd0, irq_busoff}, 16'h0001);
        wr(2'd0, 16'h0004);
        @(negedge clk);
        peek(2'd0, d); check("R5 no refire while busoff", d & 16'h0004, 16'h0000);
        check("R8 busoff irq cleared", {15'd0, irq_busoff}, 16'h0000);
        wr(2'd3, 16'h0000);
        tx_err_cnt = 9'd0;
        @(negedge clk); tx_err_cnt = 9'd300;
        @(negedge clk);
        peek(2'd0, d); check("R5 re-entry sets bit", d & 16'h0004, 16'h0004);
        check("R8 disabled busoff irq", {15'd0, irq_busoff}, 16'h0000);
        wr(2'd3, 16'h0080);
        check("R8 enable busoff irq", {15'd0, irq_busoff}, 16'h0001);
        wr(2'd0, 16'h0004);
        wr(2'd3, 16'h0000);
        tx_err_cnt = 9'd0;
    endtask

    task automatic t_err_irq();
        logic [15:0] d;
        wr(2'd1, 16'hFFFF);
        @(negedge clk); ev_stuff = 1;
        @(negedge clk); clear_pulses();
        check("R8 err irq disabled", {14'd0, irq_err, irq_mbox}, 16'h0000);
        wr(2'd3, 16'h0040);
        check("R8 err irq enabled, mask unrelated", {14'd0, irq_err, irq_mbox}, 16'h0002);
        @(negedge clk);
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h0002; ev_form = 1;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; clear_pulses();
        peek(2'd0, d); check("R5 set beats clear", d & 16'h0002, 16'h0002);
        @(negedge clk); ev_wake = 1;
        @(negedge clk); clear_pulses();
        peek(2'd0, d); check("R5 wake bit", d & 16'h0001, 16'h0001);
        wr(2'd0, 16'h0003);
        peek(2'd0, d); check("R5 w1c both", d & 16'h0007, 16'h0000);
        check("R8 err irq off", {15'd0, irq_err}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_mbox();
        t_capture();
        t_levels();
        t_busoff();
        t_err_irq();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule